// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Cascade Carry

This block is a binary up-counter, 4 bits wide by default, in which every state bit changes on the same rising clock edge. The counter has no reset pin. On each edge it does one of four things: it clears to zero, it takes a parallel preset word, it advances by one, or it keeps its value. The decision uses only the levels of the control inputs sampled at that edge. Clear and preset are both active low and both synchronous, and both override the count enables.

Counting needs two enables. One is a local (parallel) enable. The other is a chain (trickle) enable that is also passed forward. The carry output is combinational. It goes high when the chain enable is high and the count is all ones, so it can drive the chain enable of the next, more significant stage. A long counter is built by connecting one stage's carry to the next stage's chain enable and sharing the clock and the local enable. A shorter modulus is made by decoding a terminal count onto the clear input.

The register content is undefined at power-up until the first clear edge.

Top module: `presettable_counter`

## Requirements
- R1: All count bits are updated together, only on a rising clock edge. A control pulse that starts and ends between two edges leaves the count unchanged.
- R2: When `clearN` is low at an edge, the count becomes 0 after that edge, whatever `enPar` and `enTrk` are.
- R3: When `loadN` is low and `clearN` is high at an edge, the count becomes `dataIn` after that edge, whatever the enables are. Bit 0 of `dataIn` lands in bit 0 of `count`, which is the least significant bit.
- R4: When `clearN` and `loadN` are both low at the same edge, the clear wins and the count becomes 0.
- R5: With `clearN` and `loadN` high and both `enPar` and `enTrk` high, the count increases by one at each edge. From the all-ones value it wraps to 0.
- R6: With `clearN` and `loadN` high and either enable low, the count holds its value.
- R7: `carryOut` is high exactly when `enTrk` is high and the count equals all ones (15 for the default width). It follows `enTrk` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel preset, active low |
| dataIn | input | WIDTH | Preset word, bit 0 least significant |
| enPar | input | 1 | Local count enable |
| enTrk | input | 1 | Chain count enable, also gates the carry |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | Cascade carry: chain enable AND count all ones |

## Verification
On every edge after the first clear, the assertions check the mode priority: clear gives zero, load gives the sampled preset word, both enables give an increment modulo the width, and anything else gives a hold. They also check the carry's relation to the chain enable and the terminal count on every cycle.

Some behaviour only the bench's scenarios can show:
- The named reference run from clear through preset 12 to the wrap and the inhibited hold at 2.
- A control pulse placed wholly between edges having no effect.
- The carry responding to the chain enable mid-cycle with no edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Strobes passed from mode decode to the datapath; at most one is set.
  typedef struct packed {
    logic zeroIt;
    logic presetIt;
    logic stepIt;
  } ctrStrobes_t;

endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enPar,
  input  logic        enTrk,
  output ctrStrobes_t strobes
);

  // Priority: clear, then preset, then count; otherwise hold.
  always_comb begin
    strobes = '0;
    if (!clearN)             strobes.zeroIt   = 1'b1;
    else if (!loadN)         strobes.presetIt = 1'b1;
    else if (enPar && enTrk) strobes.stepIt   = 1'b1;
  end

endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrStrobes_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             enTrk,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countD;

  always_comb begin
    countD = countQ;
    if (strobes.zeroIt)        countD = '0;
    else if (strobes.presetIt) countD = dataIn;
    else if (strobes.stepIt)   countD = WIDTH'(countQ + 1'b1);
  end

  // Single register: every bit is clocked by the same edge.
  always_ff @(posedge clk) begin
    countQ <= countD;
  end

  assign count    = countQ;
  assign carryOut = enTrk && (countQ == TERMINAL);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             enPar,
  input  logic             enTrk,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  ctrStrobes_t strobes;

  ctr_ctrl u_ctrl (
    .clearN  (clearN),
    .loadN   (loadN),
    .enPar   (enPar),
    .enTrk   (enTrk),
    .strobes (strobes)
  );

  ctr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .enTrk    (enTrk),
    .count    (count),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic [WIDTH-1:0] dataIn,
  input logic             enPar,
  input logic             enTrk,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);

  // The content is undefined until the first clear, so all checks wait for it.
  bit seenClear;
  always_ff @(posedge clk) begin
    if (!clearN) seenClear <= 1'b1;
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!seenClear)
    !clearN |=> (count == '0));

  a_r3_load_data: assert property (@(posedge clk) disable iff (!seenClear)
    (clearN && !loadN) |=> (count == $past(dataIn)));

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!seenClear)
    (!clearN && !loadN) |=> (count == '0));

  a_r5_step_wrap: assert property (@(posedge clk) disable iff (!seenClear)
    (clearN && loadN && enPar && enTrk) |=> (count == WIDTH'($past(count) + 1'b1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!seenClear)
    (clearN && loadN && !(enPar && enTrk)) |=> $stable(count));

  a_r7_carry_needs_max: assert property (@(posedge clk) disable iff (!seenClear)
    carryOut |-> (enTrk && (&count)));

  a_r7_carry_when_max: assert property (@(posedge clk) disable iff (!seenClear)
    (enTrk && (&count)) |-> carryOut);

endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .dataIn   (dataIn),
  .enPar    (enPar),
  .enTrk    (enTrk),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clearN = 1'b1;
  logic         loadN = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic         enPar = 1'b0;
  logic         enTrk = 1'b0;
  logic [W-1:0] count;
  logic         carryOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  presettable_counter #(.WIDTH(W)) u0 (
    .clk(clk), .clearN(clearN), .loadN(loadN), .dataIn(dataIn),
    .enPar(enPar), .enTrk(enTrk), .count(count), .carryOut(carryOut)
  );

  // Wait for a rising edge and let the registers settle; inputs change here.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ctl(input bit c, input bit l, input bit p, input bit t);
    clearN = c; loadN = l; enPar = p; enTrk = t;
  endtask

  task automatic testClear();
    ctl(0, 1, 1, 1); tick();
    chk("R2 clear with enables high", count, 0);
    ctl(1, 0, 0, 0); dataIn = 4'd9; tick();
    ctl(0, 1, 0, 1); tick();
    chk("R2 clear with enPar low", count, 0);
  endtask

  task automatic testReference();
    int expSeq[6] = '{13, 14, 15, 0, 1, 2};
    ctl(0, 1, 0, 0); tick();
    chk("R2 reference clear", count, 0);
    ctl(1, 0, 0, 0); dataIn = 4'd12; tick();
    chk("R3 reference preset 12", count, 12);
    ctl(1, 1, 1, 1);
    foreach (expSeq[i]) begin
      tick();
      chk("R5 reference count", count, expSeq[i]);
      chk("R7 reference carry", carryOut, (expSeq[i] == 15) ? 1 : 0);
    end
    ctl(1, 1, 0, 1); tick(); tick();
    chk("R6 inhibit holds at 2", count, 2);
  endtask

  task automatic testLoadOrder();
    ctl(1, 0, 0, 0); dataIn = 4'b0001; tick();
    chk("R3 load bit0 is LSB, enables low", count, 1);
    ctl(1, 0, 1, 1); dataIn = 4'b1000; tick();
    chk("R3 load overrides enables high", count, 8);
    ctl(0, 0, 1, 1); dataIn = 4'd7; tick();
    chk("R4 clear beats load", count, 0);
  endtask

  task automatic testHold();
    ctl(1, 0, 0, 0); dataIn = 4'd5; tick();
    ctl(1, 1, 1, 0); tick();
    chk("R6 hold enTrk low", count, 5);
    ctl(1, 1, 0, 0); tick();
    chk("R6 hold both low", count, 5);
    ctl(1, 1, 1, 1); tick();
    chk("R5 step after hold", count, 6);
  endtask

  task automatic testCarryComb();
    ctl(1, 0, 0, 0); dataIn = 4'd15; tick();
    ctl(1, 1, 0, 0); #3;
    chk("R7 carry low with enTrk low at 15", carryOut, 0);
    enTrk = 1'b1; #1;
    chk("R7 carry follows enTrk without edge", carryOut, 1);
    enTrk = 1'b0; #1;
    chk("R7 carry drops with enTrk", carryOut, 0);
    chk("R6 no edge, count still 15", count, 15);
    ctl(1, 1, 1, 1); tick();
    chk("R5 wrap 15 to 0", count, 0);
    chk("R7 carry low at 0", carryOut, 0);
  endtask

  task automatic testBetweenEdges();
    ctl(1, 0, 0, 0); dataIn = 4'd3; tick();
    ctl(1, 1, 0, 0);
    #3 clearN = 1'b0;
    #3 clearN = 1'b1;
    #2 loadN = 1'b0; dataIn = 4'd11;
    #3 loadN = 1'b1;
    tick();
    chk("R1 mid-cycle pulses ignored", count, 3);
  endtask

  initial begin
    tick();
    testClear();
    testReference();
    testLoadOrder();
    testHold();
    testCarryComb();
    testBetweenEdges();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule